// File: doc/BRIEF.md
# Pointer-Addressed Console Port

This block is a byte-wide console endpoint with two bus locations. The control location works through a pointer. A write to it stores the byte as the pointer for the next status read, and the byte 0x28 also acknowledges a transmit interrupt. A read of the control location returns a general status byte. When the pointer holds 3, the read instead returns a code that names the interrupt source, and the pointer then goes back to 0. The data location sends a byte to a character output on write, and on read it pops the oldest byte from an internal receive queue.

Two pending bits, transmit and receive, drive a level interrupt. Protocol misuse sets a sticky error flag that only reset clears. Misuse means an acknowledge with no transmit pending, or a data read from an empty queue. The bus has a single request strobe. Every read returns its data exactly one cycle after the request.

Top module: `console_port`

## Requirements
- R1: After reset the interrupt, the error flag and the character strobe are low, and a control read returns 0x04 because the pointer is 0.
- R2: A control write of any byte stores it as the pointer. With the pointer not equal to 3, a control read returns 0x04, with bit 0 also set while receive is pending.
- R3: With the pointer equal to 3, a control read returns 0x10 if transmit is pending, otherwise 0x20 if receive is pending, otherwise 0x00. The read sets the pointer to 0.
- R4: A data write (offset 0xC0) presents the byte on the character output for one cycle, in the cycle after the request. It sets transmit pending and raises the interrupt in that same cycle.
- R5: A control write (offset 0x80) of 0x28 clears transmit pending. The interrupt then drops unless receive is pending.
- R6: An acknowledge while transmit pending is clear sets the error flag, which stays set until reset.
- R7: A receive push stores the byte, sets receive pending and raises the interrupt regardless of any other state.
- R8: A data read returns queued bytes in arrival order. The read that empties the queue clears receive pending.
- R9: A data read with an empty queue returns 0x00 and sets the error flag.
- R10: The interrupt is high exactly when transmit or receive is pending.
- R11: Reads of any address other than 0x80 and 0xC0 return 0x00. Writes to such addresses change no state.
- R12: A receive push into a full queue is dropped, and the queued bytes are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the port |
| wdata_i | input | 8 | Write data |
| rvalid_o | output | 1 | Read response valid, one cycle after a read request |
| rdata_o | output | 8 | Read response data |
| tx_valid_o | output | 1 | Outgoing character strobe |
| tx_data_o | output | 8 | Outgoing character |
| rx_push_i | input | 1 | New received byte available |
| rx_data_i | input | 8 | Received byte |
| irq_o | output | 1 | Level interrupt |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
Every registered result is due exactly one clock edge after its stimulus edge. This covers read data, the character strobe, the interrupt and the error flag. The driver pushes each expected read byte into a queue before it issues the request. A monitor pops and compares entries on the falling edge after the response edge, when rvalid_o is high. The level outputs are sampled on the falling edge after the driving task returns, which is one edge after the request and before any other stimulus. Pointer effects are observed through follow-up control reads. Effects on the queue are observed through follow-up data reads.

// File: rtl/console_port_pkg.sv
package console_port_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [7:0] OFS_CTRL = 8'h80;
  localparam logic [7:0] OFS_DATA = 8'hC0;

  localparam logic [7:0] CODE_TX_ACK = 8'h28;
  localparam logic [7:0] PTR_SOURCE  = 8'h03;

  localparam int unsigned BIT_RX_RDY  = 0;
  localparam int unsigned BIT_ALWAYS  = 2;
  localparam int unsigned BIT_SRC_TX  = 4;
  localparam int unsigned BIT_SRC_RX  = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } sel_e;
endpackage

// File: rtl/console_rx_fifo.sv
module console_rx_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              last_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full, do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);
  assign last_o  = (cnt_q == CNT_W'(1));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == IDX_MAX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == IDX_MAX) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && wr_q == IDX_W'(g)) mem_q[g] <= data_i;
    end
  end
endmodule

// File: rtl/console_port_decode.sv
module console_port_decode
  import console_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  always_comb begin
    if (addr_i == A_CTRL)      sel_o = SEL_CTRL;
    else if (addr_i == A_DATA) sel_o = SEL_DATA;
    else                       sel_o = SEL_NONE;
  end
endmodule

// File: rtl/console_port_regs.sv
module console_port_regs
  import console_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  sel_e              sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rx_push_i,
  input  logic              rx_empty_i,
  input  logic              rx_last_i,
  input  logic [BYTE_W-1:0] rx_head_i,
  output logic              rx_pop_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              tx_pend_o,
  output logic              rx_pend_o,
  output logic              err_o,
  output logic              rvalid_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o
);
  logic [BYTE_W-1:0] ptr_q, rd_mux, stat_byte;
  logic tx_q, rx_q, err_q;
  logic ctrl_wr, ctrl_rd, data_wr, data_rd, ack, src_rd;

  assign ctrl_wr = req_i && we_i  && sel_i == SEL_CTRL;
  assign ctrl_rd = req_i && !we_i && sel_i == SEL_CTRL;
  assign data_wr = req_i && we_i  && sel_i == SEL_DATA;
  assign data_rd = req_i && !we_i && sel_i == SEL_DATA;
  assign ack     = ctrl_wr && wdata_i == CODE_TX_ACK;
  assign src_rd  = ctrl_rd && ptr_q == PTR_SOURCE;
  assign rx_pop_o = data_rd && !rx_empty_i;

  always_comb begin
    stat_byte = '0;
    if (ptr_q == PTR_SOURCE) begin
      if (tx_q)      stat_byte[BIT_SRC_TX] = 1'b1;
      else if (rx_q) stat_byte[BIT_SRC_RX] = 1'b1;
    end else begin
      stat_byte[BIT_ALWAYS] = 1'b1;
      stat_byte[BIT_RX_RDY] = rx_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_rd) rd_mux = stat_byte;
    else if (data_rd && !rx_empty_i) rd_mux = rx_head_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      tx_q       <= 1'b0;
      rx_q       <= 1'b0;
      err_q      <= 1'b0;
      rvalid_o   <= 1'b0;
      rdata_o    <= '0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      rvalid_o   <= req_i && !we_i;
      rdata_o    <= rd_mux;
      tx_valid_o <= data_wr;
      if (data_wr) tx_data_o <= wdata_i;

      if (ctrl_wr)     ptr_q <= wdata_i;
      else if (src_rd) ptr_q <= '0;

      if (data_wr)  tx_q <= 1'b1;
      else if (ack) tx_q <= 1'b0;

      if (rx_push_i)                   rx_q <= 1'b1;
      else if (rx_pop_o && rx_last_i)  rx_q <= 1'b0;

      if ((ack && !tx_q) || (data_rd && rx_empty_i)) err_q <= 1'b1;
    end
  end

  assign ptr_o     = ptr_q;
  assign tx_pend_o = tx_q;
  assign rx_pend_o = rx_q;
  assign err_o     = err_q;
endmodule

// File: rtl/console_port.sv
module console_port
  import console_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              rvalid_o,
  output logic [7:0]        rdata_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_data_i,
  output logic              irq_o,
  output logic              err_o
);
  sel_e              sel;
  logic              rx_empty, rx_last, rx_pop;
  logic [BYTE_W-1:0] rx_head, ptr_q;
  logic              tx_pend_q, rx_pend_q;

  console_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  console_rx_fifo #(.DEPTH(RX_DEPTH), .DATA_W(BYTE_W)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop),
    .head_o  (rx_head),
    .empty_o (rx_empty),
    .last_o  (rx_last)
  );

  console_port_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .rx_push_i  (rx_push_i),
    .rx_empty_i (rx_empty),
    .rx_last_i  (rx_last),
    .rx_head_i  (rx_head),
    .rx_pop_o   (rx_pop),
    .ptr_o      (ptr_q),
    .tx_pend_o  (tx_pend_q),
    .rx_pend_o  (rx_pend_q),
    .err_o      (err_o),
    .rvalid_o   (rvalid_o),
    .rdata_o    (rdata_o),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  assign irq_o = tx_pend_q | rx_pend_q;
endmodule

// File: rtl/console_port_chk.sv
module console_port_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              rx_push_i,
  input logic              rvalid_o,
  input logic              tx_valid_o,
  input logic              irq_o,
  input logic              err_o,
  input logic              rx_empty,
  input logic [7:0]        ptr_q,
  input logic              rx_pend_q
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(8'hC0);

  assert_tx_emit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == A_DATA |=> tx_valid_o && irq_o);

  assert_rx_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i |=> irq_o);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_empty_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == A_DATA && rx_empty |=> err_o);

  assert_ack_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == A_CTRL && wdata_i == 8'h28 && !rx_pend_q && !rx_push_i
    |=> !irq_o);

  assert_ptr_rewind_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && addr_i == A_CTRL && ptr_q == 8'h03 |=> ptr_q == 8'h00);

  assert_read_resp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);
endmodule

bind console_port console_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rx_push_i  (rx_push_i),
  .rvalid_o   (rvalid_o),
  .tx_valid_o (tx_valid_o),
  .irq_o      (irq_o),
  .err_o      (err_o),
  .rx_empty   (rx_empty),
  .ptr_q      (ptr_q),
  .rx_pend_q  (rx_pend_q)
);

// File: tb/console_port_test.sv
module console_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic       rvalid_o, tx_valid_o, irq_o, err_o;
  logic [7:0] rdata_o, tx_data_o;
  logic       rx_push_i = 1'b0;
  logic [7:0] rx_data_i = '0;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  localparam logic [7:0] CTRL = 8'h80, DATA = 8'hC0, NONE = 8'h40;

  always #4 clk_i = ~clk_i;

  console_port uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read responses against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected read response", rdata_o, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata_o == e, t, rdata_o, e);
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk_i);
    rx_push_i = 1'b1; rx_data_i = d;
    @(negedge clk_i);
    rx_push_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(!irq_o, "R1 irq after reset", irq_o, 0);
    check(!err_o, "R1 err after reset", err_o, 0);
    check(!tx_valid_o, "R1 tx strobe after reset", tx_valid_o, 0);
    bus_rd(CTRL, 8'h04, "R1 status after reset");

    // R3 spurious source read then pointer rewind
    bus_wr(CTRL, 8'h03);
    bus_rd(CTRL, 8'h00, "R3 spurious source read");
    bus_rd(CTRL, 8'h04, "R3 pointer back to 0");

    // R4 transmit
    bus_wr(DATA, 8'h41);
    check(tx_valid_o && tx_data_o == 8'h41, "R4 tx byte", tx_data_o, 8'h41);
    check(irq_o, "R4 irq on tx", irq_o, 1);
    @(negedge clk_i);
    check(!tx_valid_o, "R4 tx strobe one cycle", tx_valid_o, 0);
    bus_wr(CTRL, 8'h03);
    bus_rd(CTRL, 8'h10, "R3 tx source");

    // R11 unmapped accesses
    bus_wr(NONE, 8'h28);
    check(irq_o, "R11 unmapped write ignored", irq_o, 1);
    bus_rd(NONE, 8'h00, "R11 unmapped read");
    bus_wr(NONE, 8'h03);
    bus_rd(CTRL, 8'h04, "R11 pointer untouched");

    // R5 ack
    bus_wr(CTRL, 8'h28);
    check(!irq_o, "R5 irq after ack", irq_o, 0);
    check(!err_o, "R5 no error on valid ack", err_o, 0);
    bus_rd(CTRL, 8'h04, "R2 status with pointer 0x28");

    // R7 receive
    rx_push(8'h11);
    check(irq_o, "R7 irq on rx", irq_o, 1);
    check(irq_o == 1'b1, "R10 irq follows rx pending", irq_o, 1);
    rx_push(8'h22);
    rx_push(8'h33);
    bus_rd(CTRL, 8'h05, "R2 status with rx pending");
    bus_wr(CTRL, 8'h03);
    bus_rd(CTRL, 8'h20, "R3 rx source");

    // R3 priority tx over rx
    bus_wr(DATA, 8'h55);
    bus_wr(CTRL, 8'h03);
    bus_rd(CTRL, 8'h10, "R3 tx has priority");
    bus_wr(CTRL, 8'h28);
    check(irq_o, "R10 irq held by rx after ack", irq_o, 1);

    // R8 drain in order
    bus_rd(DATA, 8'h11, "R8 first byte");
    bus_rd(DATA, 8'h22, "R8 second byte");
    check(irq_o, "R8 rx pending with one left", irq_o, 1);
    bus_rd(DATA, 8'h33, "R8 last byte");
    check(!irq_o, "R8 rx pending cleared", irq_o, 0);
    bus_rd(CTRL, 8'h04, "R8 status after drain");
    check(!err_o, "R9 no error yet", err_o, 0);

    // R9 empty read
    bus_rd(DATA, 8'h00, "R9 empty read data");
    check(err_o, "R9 error on empty read", err_o, 1);

    // R6 stray ack
    do_reset();
    @(negedge clk_i);
    check(!err_o, "R1 error cleared by reset", err_o, 0);
    bus_wr(CTRL, 8'h28);
    check(err_o, "R6 error on stray ack", err_o, 1);
    repeat (3) @(negedge clk_i);
    check(err_o, "R6 error sticky", err_o, 1);

    // R12 overflow
    do_reset();
    for (int i = 1; i <= 5; i++) rx_push(8'(i));
    for (int i = 1; i <= 4; i++) bus_rd(DATA, 8'(i), "R12 queued bytes kept");
    check(!irq_o, "R12 extra byte dropped", irq_o, 0);
    check(!err_o, "R12 no error before extra read", err_o, 0);

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "all read responses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule